// File: doc/BRIEF.md
# Phase Voltage Routing Crossbar

This block sits between the sample front end of a three-phase metering datapath and the per-phase power computation. Each cycle where a sample set is marked valid, it takes one voltage sample and one current sample per phase. It then hands each computation path a voltage/current pair. The current in each pair always belongs to that path's own phase. The voltage may come from a different phase, as chosen by software, so a path can pair its own current with another phase's voltage. This covers swapped or rotated voltage wiring without touching the current channels.

The routing is set by a 6-bit field inside a wider configuration word, starting at bit 8. It holds one 2-bit selector per physical voltage input. Each selector names the path that input should feed, with an encoding that rotates relative to its own phase. Code 0 and the reserved code 3 keep the input on its own path. Code 1 moves it one phase forward (A to B, B to C, C to A), and code 2 moves it two phases forward.

If several inputs aim at the same path, the lowest-lettered input is used. A path that no input aims at receives a zero voltage. All outputs are registered. The routing field is read on the valid cycle itself, so a change of configuration applies to the next valid sample set.

Top module: `vsteer_xbar`

## Requirements
- R1: While reset is asserted, and after it until the first valid sample, `out_valid` is 0 and every voltage and current output is 0.
- R2: The selector for voltage input A is cfg bits 9:8. Code 00 routes A to path A, 01 routes it to path B, and 10 routes it to path C.
- R3: The selector for voltage input B is cfg bits 11:10. Code 00 routes B to path B, 01 routes it to path C, and 10 routes it to path A.
- R4: The selector for voltage input C is cfg bits 13:12. Code 00 routes C to path C, 01 routes it to path A, and 10 routes it to path B.
- R5: Selector code 11 behaves exactly like code 00 for its input. A field value of all zeros gives each path its own phase voltage.
- R6: Each path's current output equals that path's own phase current input from the same valid sample set, whatever the configuration.
- R7: When more than one voltage input selects the same path, that path carries the voltage with the lowest letter (A before B before C).
- R8: A path that no voltage input selects outputs a voltage of zero.
- R9: Outputs update on the clock edge that samples `in_valid` high. `out_valid` is high in exactly the cycle after each valid input cycle.
- R10: While `in_valid` is low, all data outputs hold their previous values, even if the samples or the configuration change.
- R11: Configuration bits outside 13:8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample set on the inputs is valid this cycle |
| cfg_word | input | 32 | Configuration word; routing field in bits 13:8 |
| v_in | input | 72 | Voltage samples, phase A in bits 23:0, B in 47:24, C in 71:48 |
| i_in | input | 72 | Current samples, same packing as `v_in` |
| out_valid | output | 1 | Output pairs updated in the previous edge |
| v_out | output | 72 | Voltage delivered to paths A, B, C (same packing) |
| i_out | output | 72 | Current delivered to paths A, B, C (same packing) |

## Verification
The main sweep runs every one of the 64 values of the routing field. In each run the three voltage inputs carry different values, and those values change from one configuration to the next. This way a wrong source, a stale sample and a missing zero fill all show up as distinct mismatches. The sweep covers the rotations, the two-way and three-way collisions that test priority order, and the reserved code in every position. The unused configuration bits are also filled with a changing pattern. Separate idle-cycle tests change the samples and the configuration while `in_valid` is low, which separates held outputs from outputs that follow the inputs combinationally.

// File: rtl/vsteer_pkg.sv
package vsteer_pkg;
   // Phase count and selector width used by the default configuration
   localparam int unsigned PHASES     = 3;
   localparam int unsigned SEL_BITS   = 2;
   // Selector codes with fixed meaning
   localparam int unsigned CODE_OWN   = 0;

   // Rotating destination for a source: code 0 or any code >= phases keeps
   // the source on its own path, otherwise move forward by code phases.
   function automatic int unsigned dest_of(input int unsigned src,
                                           input int unsigned code,
                                           input int unsigned nph);
      if (code == CODE_OWN || code >= nph) return src;
      return (src + code) % nph;
   endfunction
endpackage

// File: rtl/vsteer_decode.sv
module vsteer_decode #(
   parameter int unsigned NPH   = 3,
   parameter int unsigned SEL_W = 2,
   parameter int unsigned SRC   = 0
) (
   input  logic [SEL_W-1:0] sel,
   output logic [NPH-1:0]   dest
);
   import vsteer_pkg::*;

   if (SRC >= NPH) begin : g_bad_src
      $error("vsteer_decode: SRC out of range");
   end

   int unsigned tgt;

   always_comb begin
      tgt = dest_of(SRC, int'(sel), NPH);
      for (int d = 0; d < NPH; d++) begin
         dest[d] = (tgt == d);
      end
   end
endmodule

// File: rtl/vsteer_pick.sv
module vsteer_pick #(
   parameter int unsigned NPH = 3,
   parameter int unsigned SW  = 24
) (
   input  logic [NPH-1:0]    req,
   input  logic [NPH*SW-1:0] v_flat,
   output logic [SW-1:0]     v_sel
);
   logic hit;

   // Lowest index wins; empty request set yields zero
   always_comb begin
      v_sel = '0;
      hit   = 1'b0;
      for (int s = 0; s < NPH; s++) begin
         if (req[s] && !hit) begin
            v_sel = v_flat[s*SW +: SW];
            hit   = 1'b1;
         end
      end
   end
endmodule

// File: rtl/vsteer_stage.sv
module vsteer_stage #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/vsteer_xbar.sv
module vsteer_xbar #(
   parameter int unsigned NPH     = vsteer_pkg::PHASES,
   parameter int unsigned SW      = 24,
   parameter int unsigned SEL_W   = vsteer_pkg::SEL_BITS,
   parameter int unsigned CFG_W   = 32,
   parameter int unsigned SEL_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic [NPH*SW-1:0] v_in,
   input  logic [NPH*SW-1:0] i_in,
   output logic              out_valid,
   output logic [NPH*SW-1:0] v_out,
   output logic [NPH*SW-1:0] i_out
);
   localparam int unsigned FIELD_W = NPH * SEL_W;
   localparam int unsigned BUS_W   = NPH * SW;

   // Elaboration-time parameter checks
   if (NPH < 2) begin : g_bad_nph
      $error("vsteer_xbar: NPH must be at least 2");
   end
   if ((1 << SEL_W) < NPH) begin : g_bad_sel
      $error("vsteer_xbar: SEL_W too narrow for NPH");
   end
   if (SEL_LSB + FIELD_W > CFG_W) begin : g_bad_field
      $error("vsteer_xbar: routing field exceeds cfg width");
   end
   if (SW < 1) begin : g_bad_sw
      $error("vsteer_xbar: SW must be positive");
   end

   logic [FIELD_W-1:0] field;
   assign field = cfg_word[SEL_LSB +: FIELD_W];

   // route[s][d]: source s aims at destination d
   logic [NPH-1:0] route [NPH];
   logic [BUS_W-1:0] v_next;

   for (genvar s = 0; s < NPH; s++) begin : g_src
      vsteer_decode #(.NPH(NPH), .SEL_W(SEL_W), .SRC(s)) u_dec (
         .sel  (field[s*SEL_W +: SEL_W]),
         .dest (route[s])
      );
   end

   for (genvar d = 0; d < NPH; d++) begin : g_dst
      logic [NPH-1:0] req;
      for (genvar s = 0; s < NPH; s++) begin : g_req
         assign req[s] = route[s][d];
      end
      vsteer_pick #(.NPH(NPH), .SW(SW)) u_pick (
         .req    (req),
         .v_flat (v_in),
         .v_sel  (v_next[d*SW +: SW])
      );
   end

   vsteer_stage #(.W(BUS_W)) u_vreg (
      .clk (clk), .rst_n (rst_n), .load (in_valid), .d (v_next), .q (v_out)
   );
   vsteer_stage #(.W(BUS_W)) u_ireg (
      .clk (clk), .rst_n (rst_n), .load (in_valid), .d (i_in), .q (i_out)
   );
   vsteer_stage #(.W(1)) u_vld (
      .clk (clk), .rst_n (rst_n), .load (1'b1), .d (in_valid), .q (out_valid)
   );
endmodule

// File: rtl/vsteer_xbar_chk.sv
module vsteer_xbar_chk #(
   parameter int unsigned NPH     = 3,
   parameter int unsigned SW      = 24,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned CFG_W   = 32,
   parameter int unsigned SEL_LSB = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [CFG_W-1:0]  cfg_word,
   input logic [NPH*SW-1:0] v_in,
   input logic [NPH*SW-1:0] i_in,
   input logic              out_valid,
   input logic [NPH*SW-1:0] v_out,
   input logic [NPH*SW-1:0] i_out
);
   // R9: valid strobe follows input strobe by one cycle
   a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10: idle cycles leave the data outputs untouched
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(v_out) && $stable(i_out)));
   // R6: currents pass straight through
   a_r6_current: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (i_out == $past(i_in)));
   // R5: all-zero routing field is the identity mapping
   a_r5_identity: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cfg_word[SEL_LSB +: NPH*SEL_W] == '0) |=> (v_out == $past(v_in)));
   // R1: nothing valid while in reset
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (out_valid == 1'b0);
      end
   end
endmodule

bind vsteer_xbar vsteer_xbar_chk #(
   .NPH(NPH), .SW(SW), .SEL_W(SEL_W), .CFG_W(CFG_W), .SEL_LSB(SEL_LSB)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_word(cfg_word),
   .v_in(v_in), .i_in(i_in), .out_valid(out_valid), .v_out(v_out), .i_out(i_out)
);

// File: tb/sim_vsteer_xbar.sv
module sim_vsteer_xbar;
   localparam int NPH = 3;
   localparam int SW  = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [31:0]       cfg_word = '0;
   logic [NPH*SW-1:0] v_in = '0;
   logic [NPH*SW-1:0] i_in = '0;
   logic              out_valid;
   logic [NPH*SW-1:0] v_out;
   logic [NPH*SW-1:0] i_out;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   vsteer_xbar u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_word(cfg_word),
      .v_in(v_in), .i_in(i_in), .out_valid(out_valid), .v_out(v_out), .i_out(i_out)
   );

   task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Destination of source s for code c, from R2..R5
   function automatic int dst(input int s, input int c);
      if (c == 0 || c == 3) return s;
      return (s + c) % 3;
   endfunction

   function automatic logic [SW-1:0] vsamp(input int k, input int s);
      return SW'(32'h0A0000 + k * 16 + s + 1);
   endfunction
   function automatic logic [SW-1:0] isamp(input int k, input int s);
      return SW'(32'hC00000 + k * 256 + s * 7 + 3);
   endfunction

   // Present one valid set at a negedge; return at the next negedge
   task automatic push(input logic [31:0] cfg, input int k);
      @(negedge clk);
      cfg_word = cfg;
      for (int s = 0; s < NPH; s++) begin
         v_in[s*SW +: SW] = vsamp(k, s);
         i_in[s*SW +: SW] = isamp(k, s);
      end
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [SW-1:0] held_v [NPH];
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 out_valid", SW'(out_valid), '0);
      check("R1 v_out", v_out[SW-1:0] | v_out[2*SW-1:SW] | v_out[3*SW-1:2*SW], '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", SW'(out_valid), '0);
      check("R1 i_out", i_out[SW-1:0] | i_out[2*SW-1:SW] | i_out[3*SW-1:2*SW], '0);

      // Sweep every routing field value (R2, R3, R4, R5, R7, R8, R11, R6, R9)
      for (int f = 0; f < 64; f++) begin
         logic [31:0] cfg;
         cfg = {18'(f * 9137 + 5), 6'(f), 8'(f * 37 + 11)}; // R11 noise outside 13:8
         push(cfg, f);
         check("R9 out_valid", SW'(out_valid), SW'(1));
         for (int d = 0; d < NPH; d++) begin
            int cnt;
            int win;
            logic [SW-1:0] expv;
            string tag;
            cnt = 0; win = -1;
            for (int s = 0; s < NPH; s++) begin
               if (dst(s, (f >> (2*s)) & 3) == d) begin
                  cnt++;
                  if (win < 0) win = s;
               end
            end
            expv = (win < 0) ? '0 : vsamp(f, win);
            if (win < 0)      tag = "R8 unselected";
            else if (cnt > 1) tag = "R7 collision";
            else if (((f >> (2*win)) & 3) == 3) tag = "R5 reserved";
            else if (win == 0) tag = "R2 source A";
            else if (win == 1) tag = "R3 source B";
            else               tag = "R4 source C";
            check($sformatf("%s cfg=%0d path=%0d R11", tag, f, d), v_out[d*SW +: SW], expv);
            check($sformatf("R6 cfg=%0d path=%0d", f, d), i_out[d*SW +: SW], isamp(f, d));
         end
      end

      // R9: strobe drops after an idle cycle
      @(negedge clk);
      check("R9 out_valid low", SW'(out_valid), '0);

      // R10: change cfg and samples with in_valid low; outputs must hold
      push(32'h0000_1500, 99); // full rotation
      for (int d = 0; d < NPH; d++) held_v[d] = v_out[d*SW +: SW];
      check("R2 rotation path B", held_v[1], vsamp(99, 0));
      check("R3 rotation path C", held_v[2], vsamp(99, 1));
      check("R4 rotation path A", held_v[0], vsamp(99, 2));
      cfg_word = 32'h0000_2A00;
      for (int s = 0; s < NPH; s++) begin
         v_in[s*SW +: SW] = vsamp(200, s);
         i_in[s*SW +: SW] = isamp(200, s);
      end
      repeat (3) @(negedge clk);
      for (int d = 0; d < NPH; d++) begin
         check($sformatf("R10 hold v path=%0d", d), v_out[d*SW +: SW], held_v[d]);
         check($sformatf("R10 hold i path=%0d", d), i_out[d*SW +: SW], isamp(99, d));
      end

      // Configuration applies on the next valid set (R9, R4)
      push(32'h0000_2A00, 201);
      check("R2 code 10 path C", v_out[2*SW +: SW], vsamp(201, 0));
      check("R3 code 10 path A", v_out[0 +: SW], vsamp(201, 1));
      check("R4 code 10 path B", v_out[SW +: SW], vsamp(201, 2));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule